// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between six PWM gate commands for a three-phase bridge and the six gate-enable outputs that reach the drivers. Commands and outputs are both active high. The block watches five kinds of digital protection flag. One flag comes from a short-circuit comparator on the low-side switches. Two flags describe the low-side control supply: one below the trip level and one above the reset level. The other two describe the three high-side supplies in the same way, one pair per phase. From these flags the block decides which gates must be blanked, and it drives an active-low fault line toward the host controller.

The two sides are handled differently. A short circuit or a low-side supply undervoltage blanks all three low-side gates at once and pulls the fault line low. A high-side undervoltage blanks only the high-side gate of its own phase and never touches the fault line. After any blanking, a phase turns on again only when its own command is seen rising after the condition has cleared. A command that stays high through the event keeps its switch off. Every flag and command passes through a two-flop synchronizer first. This adds two clock cycles of latency from a pin to any output. Over-temperature is outside the block. The controller must stop the stage itself.

Top module: `gate_guard`

## Requirements
- R1: With no fault active, each gate output equals its synchronized command. A command change shows at the gate output two rising clock edges after the change reaches the input pin, once the phase has been armed by a low-to-high command edge.
- R2: When `sc_flag` is high, all three bits of `gate_lo` are 0 from the second clock edge after the flag rises, whatever `cmd_lo` is. `gate_hi` is not affected.
- R3: A rising short-circuit flag drives `fault_n` low in the same cycle that the low gates are blanked. `fault_n` stays low for exactly `FAULT_CYCLES` clock cycles and then returns high.
- R4: A new rising edge of the short-circuit flag while a fault pulse is running restarts the count. `fault_n` then stays low for `FAULT_CYCLES` cycles measured from the new edge.
- R5: After any low-side trip, a low-side phase whose command stays high stays off. It turns on only after its command goes low and then high again, once the trip has cleared.
- R6: While `uvl_trip` is high, or while its latched state persists, all bits of `gate_lo` are 0 and `fault_n` is low. A low-side undervoltage lasting even one cycle holds `fault_n` low for at least `FAULT_CYCLES` cycles.
- R7: The low-side undervoltage state is cleared only by `uvl_ok` being high while `uvl_trip` is low. Dropping `uvl_trip` alone leaves the gates blanked and `fault_n` low. When both flags are high, the trip flag wins.
- R8: `uvh_trip[i]` blanks only `gate_hi[i]`. The other gates and `fault_n` are unaffected. The phase stays blanked until `uvh_ok[i]` is high with `uvh_trip[i]` low.
- R9: After a high-side undervoltage clears, `gate_hi[i]` stays off until `cmd_hi[i]` next rises.
- R10: `stat_sc` is high for exactly the cycles of a short-circuit fault pulse. `stat_uv` is high while the low-side undervoltage state is active.
- R11: During and immediately after reset, all gate outputs are 0, `fault_n` is 1, and both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 3 | High-side gate commands, one bit per phase, active high |
| cmd_lo | input | 3 | Low-side gate commands, one bit per phase, active high |
| sc_flag | input | 1 | Low-side short-circuit comparator flag, active high |
| uvl_trip | input | 1 | Low-side supply is below its trip level |
| uvl_ok | input | 1 | Low-side supply is above its reset level |
| uvh_trip | input | 3 | Per-phase high-side supply is below its trip level |
| uvh_ok | input | 3 | Per-phase high-side supply is above its reset level |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Fault line, active low |
| stat_sc | output | 1 | A short-circuit fault pulse is in progress |
| stat_uv | output | 1 | The low-side undervoltage state is active |

## Verification
The bench holds commands high across every trip and recovery. A design that re-enabled on command level instead of on a fresh edge would switch back on into the fault, and the bench would see it. It measures the fault pulse to the exact cycle on both sides of its end. It also fires a second short-circuit edge late in a running pulse, which exposes a counter that ignores the restart or stretches the width by one. A single-cycle undervoltage glitch tests the minimum width, and dropping the trip flag without the reset-level flag tests the hysteresis. A high-side undervoltage must darken exactly one gate while `fault_n` stays high. This catches designs that route it into the shared fault path or blank the whole side.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    localparam int NPH = 3;

    // Bundle of all asynchronous inputs, synchronized together
    typedef struct packed {
        logic [NPH-1:0] cmd_hi;
        logic [NPH-1:0] cmd_lo;
        logic           sc;
        logic           uvl_trip;
        logic           uvl_ok;
        logic [NPH-1:0] uvh_trip;
        logic [NPH-1:0] uvh_ok;
    } pin_bundle_t;

    localparam int BUNDLE_W = $bits(pin_bundle_t);

    // Width of a down-counter that must hold the value n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gg_hyst.sv
module gg_hyst #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trip,
    input  logic [N-1:0] ok,
    output logic [N-1:0] active,
    output logic [N-1:0] entry
);
    logic [N-1:0] held;

    generate
        for (genvar i = 0; i < N; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)          held[i] <= 1'b0;
                else if (trip[i]) held[i] <= 1'b1;
                else if (ok[i])   held[i] <= 1'b0;
            end
            assign active[i] = trip[i] | held[i];
            assign entry[i]  = trip[i] & ~held[i];

            // R7 / R8: once latched, state survives until the reset-level flag
            hold_until_ok_chk: assert property (@(posedge clk) disable iff (rst)
                ($past(active[i]) && !ok[i] && !$past(ok[i])) |-> active[i]);
        end
    endgenerate
endmodule

// File: rtl/gg_rearm.sv
module gg_rearm #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cmd,
    input  logic [N-1:0] block,
    output logic [N-1:0] gate
);
    logic [N-1:0] cmd_prev;
    logic [N-1:0] armed_q;
    logic [N-1:0] armed_now;

    generate
        for (genvar i = 0; i < N; i++) begin : g_phase
            logic rise;
            assign rise         = cmd[i] & ~cmd_prev[i];
            assign armed_now[i] = ~block[i] & (armed_q[i] | rise);
            assign gate[i]      = cmd[i] & armed_now[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    cmd_prev[i] <= 1'b0;
                    armed_q[i]  <= 1'b0;
                end else begin
                    cmd_prev[i] <= cmd[i];
                    armed_q[i]  <= armed_now[i];
                end
            end

            // R5 / R9: a gate may only switch on together with a command edge
            edge_only_on_chk: assert property (@(posedge clk) disable iff (rst)
                (gate[i] && !$past(gate[i])) |-> (cmd[i] && !$past(cmd[i])));

            // R8: a blocked phase never drives its gate
            blocked_off_chk: assert property (@(posedge clk) disable iff (rst)
                block[i] |-> !gate[i]);
        end
    endgenerate
endmodule

// File: rtl/gg_lo_fault.sv
module gg_lo_fault
    import gate_guard_pkg::*;
#(
    parameter int FAULT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic sc_s,
    input  logic uv_active,
    input  logic uv_entry,
    output logic fault_n,
    output logic stat_sc,
    output logic stat_uv
);
    localparam int CW = cnt_width(FAULT_CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(FAULT_CYCLES - 1);

    logic          sc_prev;
    logic          sc_tag;
    logic [CW-1:0] cnt;
    logic          sc_event;
    logic          load;
    logic          running;

    assign sc_event = sc_s & ~sc_prev;
    assign load     = sc_event | uv_entry;
    assign running  = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_prev <= 1'b0;
            sc_tag  <= 1'b0;
            cnt     <= '0;
        end else begin
            sc_prev <= sc_s;
            sc_tag  <= sc_event | (sc_tag & running);
            if (load)         cnt <= RELOAD;
            else if (running) cnt <= cnt - 1'b1;
        end
    end

    assign fault_n = ~(load | running | uv_active);
    assign stat_sc = sc_event | (sc_tag & running);
    assign stat_uv = uv_active;

    // R3: a counter above one always keeps the line low next cycle
    pulse_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt > 1) |=> !fault_n);

    // R6: a fault pulse only starts from an event
    start_from_event_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> (sc_event || uv_entry || uv_active));
endmodule

// File: rtl/gate_guard.sv
module gate_guard
    import gate_guard_pkg::*;
#(
    parameter int FAULT_CYCLES = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NPH-1:0] cmd_hi,
    input  logic [NPH-1:0] cmd_lo,
    input  logic           sc_flag,
    input  logic           uvl_trip,
    input  logic           uvl_ok,
    input  logic [NPH-1:0] uvh_trip,
    input  logic [NPH-1:0] uvh_ok,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n,
    output logic           stat_sc,
    output logic           stat_uv
);
    pin_bundle_t raw, syn;

    always_comb begin
        raw.cmd_hi   = cmd_hi;
        raw.cmd_lo   = cmd_lo;
        raw.sc       = sc_flag;
        raw.uvl_trip = uvl_trip;
        raw.uvl_ok   = uvl_ok;
        raw.uvh_trip = uvh_trip;
        raw.uvh_ok   = uvh_ok;
    end

    gg_sync #(.W(BUNDLE_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (syn)
    );

    // Low-side supply hysteresis
    logic uvl_active, uvl_entry;
    gg_hyst #(.N(1)) u_hyst_lo (
        .clk    (clk),
        .rst    (rst),
        .trip   (syn.uvl_trip),
        .ok     (syn.uvl_ok),
        .active (uvl_active),
        .entry  (uvl_entry)
    );

    // High-side supply hysteresis, one lane per phase
    logic [NPH-1:0] uvh_active, uvh_entry;
    gg_hyst #(.N(NPH)) u_hyst_hi (
        .clk    (clk),
        .rst    (rst),
        .trip   (syn.uvh_trip),
        .ok     (syn.uvh_ok),
        .active (uvh_active),
        .entry  (uvh_entry)
    );

    logic [NPH-1:0] blk_lo;
    assign blk_lo = {NPH{syn.sc | uvl_active}};

    gg_rearm #(.N(NPH)) u_rearm_lo (
        .clk   (clk),
        .rst   (rst),
        .cmd   (syn.cmd_lo),
        .block (blk_lo),
        .gate  (gate_lo)
    );

    gg_rearm #(.N(NPH)) u_rearm_hi (
        .clk   (clk),
        .rst   (rst),
        .cmd   (syn.cmd_hi),
        .block (uvh_active),
        .gate  (gate_hi)
    );

    gg_lo_fault #(.FAULT_CYCLES(FAULT_CYCLES)) u_fault (
        .clk       (clk),
        .rst       (rst),
        .sc_s      (syn.sc),
        .uv_active (uvl_active),
        .uv_entry  (uvl_entry),
        .fault_n   (fault_n),
        .stat_sc   (stat_sc),
        .stat_uv   (stat_uv)
    );

    // R2: short circuit seen means every low gate is dark
    sc_blanks_lo_chk: assert property (@(posedge clk) disable iff (rst)
        syn.sc |-> (gate_lo == '0));

    // R3: the short-circuit edge reaches the fault line in the same cycle
    sc_raises_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(syn.sc) |-> !fault_n);

    // R6: low-side undervoltage blanks the low side
    uv_blanks_lo_chk: assert property (@(posedge clk) disable iff (rst)
        uvl_active |-> (gate_lo == '0 && !fault_n));

    // R8: high-side undervoltage leaves the low side alone
    hi_uv_local_chk: assert property (@(posedge clk) disable iff (rst)
        (uvh_entry != '0 && !syn.sc && !uvl_active && $past(fault_n) && $past(gate_lo) == syn.cmd_lo
            && $past(syn.cmd_lo) == syn.cmd_lo && $past(blk_lo) == '0) |-> fault_n);
endmodule

// File: tb/tb_gate_guard.sv
module tb_gate_guard;
    localparam int F = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] cmd_hi, cmd_lo, uvh_trip, uvh_ok;
    logic       sc_flag, uvl_trip, uvl_ok;
    logic [2:0] gate_hi, gate_lo;
    logic       fault_n, stat_sc, stat_uv;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gate_guard #(.FAULT_CYCLES(F)) dut (
        .clk(clk), .rst(rst),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .sc_flag(sc_flag), .uvl_trip(uvl_trip), .uvl_ok(uvl_ok),
        .uvh_trip(uvh_trip), .uvh_ok(uvh_ok),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n),
        .stat_sc(stat_sc), .stat_uv(stat_uv)
    );

    // {cmd_hi, cmd_lo, sc, uvl_trip, uvl_ok, uvh_trip, uvh_ok, exp_hi, exp_lo, exp_fault_n}
    localparam logic [21:0] VEC [0:8] = '{
        22'b000_000_0_0_1_000_111_000_000_1,
        22'b101_010_0_0_1_000_111_101_010_1,
        22'b010_101_0_0_1_000_111_010_101_1,
        22'b111_111_0_0_1_000_111_111_111_1,
        22'b111_111_0_0_1_010_101_101_111_1,
        22'b111_111_0_0_1_000_101_101_111_1,
        22'b111_111_0_0_1_000_111_101_111_1,
        22'b101_111_0_0_1_000_111_101_111_1,
        22'b111_111_0_0_1_000_111_111_111_1
    };

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drop and raise low-side commands to re-arm them
    task automatic rearm_lo();
        cmd_lo = 3'b000;
        wait_n(3);
        cmd_lo = 3'b111;
        wait_n(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_hi = 3'b000; cmd_lo = 3'b000; sc_flag = 1'b0;
        uvl_trip = 1'b0; uvl_ok = 1'b1; uvh_trip = 3'b000; uvh_ok = 3'b111;
        wait_n(4);
        // R11: reset state
        chk("R11", "gate_hi", 8'(gate_hi), 8'h0);
        chk("R11", "gate_lo", 8'(gate_lo), 8'h0);
        chk("R11", "fault_n", 8'(fault_n), 8'h1);
        chk("R11", "status", 8'({stat_sc, stat_uv}), 8'h0);
        rst = 1'b0;
        wait_n(3);
        chk("R11", "fault_n after reset", 8'(fault_n), 8'h1);

        // Table: R1 rows 0-3, R8 rows 4-5, R9 rows 6-8
        for (int k = 0; k < 9; k++) begin
            string tag;
            tag = (k < 4) ? "R1" : (k < 6) ? "R8" : "R9";
            {cmd_hi, cmd_lo, sc_flag, uvl_trip, uvl_ok, uvh_trip, uvh_ok} = VEC[k][21:7];
            wait_n(3);
            chk(tag, $sformatf("row %0d gate_hi", k), 8'(gate_hi), 8'(VEC[k][6:4]));
            chk(tag, $sformatf("row %0d gate_lo", k), 8'(gate_lo), 8'(VEC[k][3:1]));
            chk(tag, $sformatf("row %0d fault_n", k), 8'(fault_n), 8'(VEC[k][0]));
        end

        // R2 / R3: short-circuit pulse, width exactly F
        sc_flag = 1'b1;
        wait_n(1);
        chk("R2", "gate_lo before sync", 8'(gate_lo), 8'h7);
        wait_n(1);
        sc_flag = 1'b0;
        chk("R2", "gate_lo blanked", 8'(gate_lo), 8'h0);
        chk("R2", "gate_hi untouched", 8'(gate_hi), 8'h7);
        chk("R3", "fault_n start", 8'(fault_n), 8'h0);
        chk("R10", "stat_sc in pulse", 8'(stat_sc), 8'h1);
        wait_n(F - 1);
        chk("R3", "fault_n last cycle", 8'(fault_n), 8'h0);
        wait_n(1);
        chk("R3", "fault_n released", 8'(fault_n), 8'h1);
        chk("R10", "stat_sc after pulse", 8'(stat_sc), 8'h0);
        // R5: held-high command stays off
        chk("R5", "gate_lo held cmd", 8'(gate_lo), 8'h0);
        rearm_lo();
        chk("R5", "gate_lo after fresh edge", 8'(gate_lo), 8'h7);

        // R4: restart of the pulse by a second edge
        sc_flag = 1'b1; wait_n(2);
        sc_flag = 1'b0; wait_n(4);
        sc_flag = 1'b1; wait_n(2);
        sc_flag = 1'b0;                   // second edge visible now (offset 8)
        wait_n(12);                       // offset 20: first pulse would be over
        chk("R4", "fault_n restarted", 8'(fault_n), 8'h0);
        wait_n(F - 13);                   // offset 8+F-1
        chk("R4", "fault_n end of second", 8'(fault_n), 8'h0);
        wait_n(1);
        chk("R4", "fault_n released", 8'(fault_n), 8'h1);
        rearm_lo();

        // R6 / R7: sustained low-side undervoltage with hysteresis
        uvl_trip = 1'b1; uvl_ok = 1'b0;
        wait_n(2);
        chk("R6", "gate_lo blanked", 8'(gate_lo), 8'h0);
        chk("R6", "fault_n low", 8'(fault_n), 8'h0);
        chk("R10", "stat_uv", 8'(stat_uv), 8'h1);
        chk("R10", "stat_sc quiet on uv", 8'(stat_sc), 8'h0);
        wait_n(28);
        chk("R6", "fault_n beyond width", 8'(fault_n), 8'h0);
        uvl_trip = 1'b0;
        wait_n(10);
        chk("R7", "fault_n trip gone, no ok", 8'(fault_n), 8'h0);
        chk("R7", "gate_lo trip gone, no ok", 8'(gate_lo), 8'h0);
        uvl_ok = 1'b1;
        wait_n(5);
        chk("R7", "fault_n recovered", 8'(fault_n), 8'h1);
        chk("R5", "gate_lo held after uv", 8'(gate_lo), 8'h0);
        rearm_lo();
        chk("R7", "gate_lo re-armed", 8'(gate_lo), 8'h7);

        // R7: trip wins over ok when both high
        uvl_trip = 1'b1;
        wait_n(3);
        chk("R7", "trip over ok", 8'(gate_lo), 8'h0);
        uvl_trip = 1'b0;
        wait_n(F + 4);
        rearm_lo();

        // R6: one-cycle undervoltage still yields full width
        uvl_trip = 1'b1;
        wait_n(1);
        uvl_trip = 1'b0;
        wait_n(F);                        // offset F+1
        chk("R6", "fault_n min width", 8'(fault_n), 8'h0);
        wait_n(1);
        chk("R6", "fault_n after min width", 8'(fault_n), 8'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule